// File: doc/BRIEF.md
# Inter-Port Mailbox Interrupt Unit

This block lets two processors, each on its own port, pass short 16-bit messages to one another and signal arrival with an interrupt. Each port owns a small bank of outgoing mailbox registers. When a port drives its box-select input low, its low address bits stop addressing memory and address a small mailbox space instead. A write to one of the port's outgoing mailboxes stores the word and raises a flag at the other port. The other port reads the message from its incoming window. That read clears the flag. Each port has one active-low interrupt output. It is the OR of that port's flags, each gated by a bit of a mask register that the port can program.

All accesses are synchronous to one clock and complete in a single cycle. There is no back-pressure: every qualified access is accepted on the rising edge where it is presented. Read data is registered. The two ports may access the unit in the same cycle without restriction.

Top module: `mbx_unit`

## Requirements
- R1: After reset every mailbox word and every flag is 0. Both 4-bit mask registers are all ones, both interrupt outputs are high, and both read-data outputs are 0.
- R2: A port access takes effect only when box_sel_n is 0, cs is 1 and at least one lane bit is set. Otherwise it changes no mailbox, flag or mask, and rdata holds.
- R3: A write (wr=1) to offset 0..3 updates outgoing mailbox N (N = offset) only in the enabled byte lanes: lane bit 0 covers data bits 7:0 and lane bit 1 covers bits 15:8.
- R4: A read (rd=1, wr=0) loads rdata on the same rising edge. Offsets 0..3 return the port's own outgoing mailbox N. Offsets 4..7 return the other port's outgoing mailbox N-4. Offset 8 returns the mask in bits 3:0 with zeros above. Any other offset returns 0. Lanes whose enable bit is 0 read as 0, and rdata holds its value when there is no read.
- R5: A write to outgoing mailbox N sets flag N at the other port on that edge.
- R6: irq_n is 0 exactly when some flag has its mask bit at 1, and it follows the flag and mask registers after the same edge.
- R7: A read of incoming offset 4+N clears the reading port's flag N on that edge. Reads of other offsets clear no flag.
- R8: If a write sets a flag and a read clears it on the same edge, the flag ends up set.
- R9: A write to offset 8 with lane bit 0 set loads the mask from wdata bits 3:0; a write with only lane bit 1 leaves the mask unchanged. Masking hides a flag from irq_n but does not clear it.
- R10: When wr and rd are both 1, the access is a write and rdata holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_box_sel_n | input | 1 | Port A mailbox mode select, active low |
| a_cs | input | 1 | Port A chip select |
| a_wr | input | 1 | Port A write strobe |
| a_rd | input | 1 | Port A read strobe |
| a_lane | input | 2 | Port A byte-lane enables |
| a_addr | input | 6 | Port A address offset |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A registered read data |
| a_irq_n | output | 1 | Port A interrupt, active low |
| b_box_sel_n | input | 1 | Port B mailbox mode select, active low |
| b_cs | input | 1 | Port B chip select |
| b_wr | input | 1 | Port B write strobe |
| b_rd | input | 1 | Port B read strobe |
| b_lane | input | 2 | Port B byte-lane enables |
| b_addr | input | 6 | Port B address offset |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B registered read data |
| b_irq_n | output | 1 | Port B interrupt, active low |

## Verification
Every result of this block is due one rising edge after its access is presented. This covers read data, flag set or clear, the mask update and the interrupt level that follows from flags and mask. The bench drives each access on a falling edge and samples both ports on the next falling edge, so there is exactly one register stage between stimulus and check. Holding cases (idle cycles, rejected accesses, write-wins-over-read) are checked on that same next falling edge by comparing against the value rdata had before. The set-versus-clear race is produced by driving both ports in the same cycle, and the result is confirmed with a follow-up read.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    RGN_OUT  = 2'd0,
    RGN_IN   = 2'd1,
    RGN_MASK = 2'd2,
    RGN_NONE = 2'd3
  } rgn_e;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int NUM_BOX = 4,
  parameter int LANES   = 2,
  localparam int IDX_W  = (NUM_BOX > 1) ? $clog2(NUM_BOX) : 1
) (
  input  logic              box_sel_n,
  input  logic              cs,
  input  logic              wr,
  input  logic              rd,
  input  logic [LANES-1:0]  lane,
  input  logic [ADDR_W-1:0] addr,
  output acc_e              kind,
  output rgn_e              rgn,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W-1:0] IN_BASE   = ADDR_W'(NUM_BOX);
  localparam logic [ADDR_W-1:0] MASK_OFFS = ADDR_W'(2 * NUM_BOX);

  logic active;

  // mailbox space is entered only with the select low, chip selected and a lane enabled
  assign active = cs && !box_sel_n && (|lane);

  always_comb begin
    if (!active)   kind = ACC_NONE;
    else if (wr)   kind = ACC_WRITE;   // write has priority over read
    else if (rd)   kind = ACC_READ;
    else           kind = ACC_NONE;
  end

  always_comb begin
    rgn = RGN_NONE;
    idx = '0;
    if (addr < IN_BASE) begin
      rgn = RGN_OUT;
      idx = IDX_W'(addr);
    end else if (addr < MASK_OFFS) begin
      rgn = RGN_IN;
      idx = IDX_W'(addr - IN_BASE);
    end else if (addr == MASK_OFFS) begin
      rgn = RGN_MASK;
    end
  end

endmodule

// File: rtl/mbx_box_bank.sv
module mbx_box_bank #(
  parameter int DATA_W  = 16,
  parameter int NUM_BOX = 4,
  localparam int LANES  = DATA_W / 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_BOX-1:0]              wr_en,
  input  logic [LANES-1:0]                lane,
  input  logic [DATA_W-1:0]               wdata,
  output logic [NUM_BOX-1:0][DATA_W-1:0]  boxes
);

  for (genvar i = 0; i < NUM_BOX; i++) begin : g_box
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          boxes[i][l*8 +: 8] <= 8'h00;
        else if (wr_en[i] && lane[l])
          boxes[i][l*8 +: 8] <= wdata[l*8 +: 8];
      end
    end
  end

  // R3: without a write strobe no mailbox word moves
  p_hold_boxes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(|wr_en) |=> $stable(boxes));

endmodule

// File: rtl/mbx_flag_ctl.sv
module mbx_flag_ctl #(
  parameter int NUM_BOX = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BOX-1:0] set,
  input  logic [NUM_BOX-1:0] clr,
  input  logic               mask_we,
  input  logic [NUM_BOX-1:0] mask_d,
  output logic [NUM_BOX-1:0] mask,
  output logic               irq_n
);

  logic [NUM_BOX-1:0] flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '1;
    end else begin
      flags <= (flags & ~clr) | set;   // a set on the same edge overrides the clear
      if (mask_we)
        mask <= mask_d;
    end
  end

  assign irq_n = ~|(flags & mask);

  for (genvar i = 0; i < NUM_BOX; i++) begin : g_chk
    p_set_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (set[i] && !clr[i]) |=> flags[i]);
    p_clear_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !flags[i]);
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && set[i]) |=> flags[i]);
  end

endmodule

// File: rtl/mbx_unit.sv
module mbx_unit
  import mbx_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 6,
  parameter int NUM_BOX = 4,
  localparam int LANES  = DATA_W / 8,
  localparam int IDX_W  = (NUM_BOX > 1) ? $clog2(NUM_BOX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_box_sel_n,
  input  logic              a_cs,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [LANES-1:0]  a_lane,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_irq_n,
  input  logic              b_box_sel_n,
  input  logic              b_cs,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [LANES-1:0]  b_lane,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_irq_n
);

  localparam int NPORT = 2;

  logic [NPORT-1:0]                            sel_n_v, cs_v, wr_v, rd_v, irq_v, mask_we_v;
  logic [NPORT-1:0][LANES-1:0]                 lane_v;
  logic [NPORT-1:0][ADDR_W-1:0]                addr_v;
  logic [NPORT-1:0][DATA_W-1:0]                wdata_v, rdata_q;
  logic [NPORT-1:0][NUM_BOX-1:0]               wr_out, rd_in, mask_v;
  logic [NPORT-1:0][NUM_BOX-1:0][DATA_W-1:0]   boxes;

  assign sel_n_v = {b_box_sel_n, a_box_sel_n};
  assign cs_v    = {b_cs, a_cs};
  assign wr_v    = {b_wr, a_wr};
  assign rd_v    = {b_rd, a_rd};
  assign lane_v  = {b_lane, a_lane};
  assign addr_v  = {b_addr, a_addr};
  assign wdata_v = {b_wdata, a_wdata};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int Q = NPORT - 1 - p;

    acc_e              kind;
    rgn_e              rgn;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] word, lane_word;

    mbx_decode #(.ADDR_W(ADDR_W), .NUM_BOX(NUM_BOX), .LANES(LANES)) u_dec (
      .box_sel_n (sel_n_v[p]),
      .cs        (cs_v[p]),
      .wr        (wr_v[p]),
      .rd        (rd_v[p]),
      .lane      (lane_v[p]),
      .addr      (addr_v[p]),
      .kind      (kind),
      .rgn       (rgn),
      .idx       (idx)
    );

    for (genvar i = 0; i < NUM_BOX; i++) begin : g_strobe
      assign wr_out[p][i] = (kind == ACC_WRITE) && (rgn == RGN_OUT) && (idx == IDX_W'(i));
      assign rd_in[p][i]  = (kind == ACC_READ)  && (rgn == RGN_IN)  && (idx == IDX_W'(i));
    end

    assign mask_we_v[p] = (kind == ACC_WRITE) && (rgn == RGN_MASK) && lane_v[p][0];

    mbx_box_bank #(.DATA_W(DATA_W), .NUM_BOX(NUM_BOX)) u_box (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_out[p]),
      .lane  (lane_v[p]),
      .wdata (wdata_v[p]),
      .boxes (boxes[p])
    );

    // flags of port p are raised by the other port's writes and cleared by p's own reads
    mbx_flag_ctl #(.NUM_BOX(NUM_BOX)) u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (wr_out[Q]),
      .clr     (rd_in[p]),
      .mask_we (mask_we_v[p]),
      .mask_d  (wdata_v[p][NUM_BOX-1:0]),
      .mask    (mask_v[p]),
      .irq_n   (irq_v[p])
    );

    always_comb begin
      case (rgn)
        RGN_OUT:  word = boxes[p][idx];
        RGN_IN:   word = boxes[Q][idx];
        RGN_MASK: word = {{(DATA_W-NUM_BOX){1'b0}}, mask_v[p]};
        default:  word = '0;
      endcase
      for (int l = 0; l < LANES; l++)
        lane_word[l*8 +: 8] = lane_v[p][l] ? word[l*8 +: 8] : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rdata_q[p] <= '0;
      else if (kind == ACC_READ)
        rdata_q[p] <= lane_word;
    end

    // R2: a port outside mailbox mode or deselected leaves its read data alone
    p_idle_rdata_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n_v[p] || !cs_v[p]) |=> $stable(rdata_q[p]));

    // R10: a write, even with the read strobe up, leaves read data alone
    p_write_no_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_v[p] |=> $stable(rdata_q[p]));
  end

  assign a_rdata = rdata_q[0];
  assign b_rdata = rdata_q[1];
  assign a_irq_n = irq_v[0];
  assign b_irq_n = irq_v[1];

endmodule

// File: tb/sim_mbx_unit.sv
`timescale 1ns/1ps
module sim_mbx_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_box_sel_n, a_cs, a_wr, a_rd, b_box_sel_n, b_cs, b_wr, b_rd;
  logic [1:0]  a_lane, b_lane;
  logic [5:0]  a_addr, b_addr;
  logic [15:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic        a_irq_n, b_irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  mbx_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .a_box_sel_n(a_box_sel_n), .a_cs(a_cs), .a_wr(a_wr), .a_rd(a_rd),
    .a_lane(a_lane), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq_n(a_irq_n),
    .b_box_sel_n(b_box_sel_n), .b_cs(b_cs), .b_wr(b_wr), .b_rd(b_rd),
    .b_lane(b_lane), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq_n(b_irq_n)
  );

  // {port, wr, rd, addr, lane, wdata, exp_rdata, exp_a_irq_n, exp_b_irq_n}
  localparam int NV = 16;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,6'd0, 2'b11,16'h1234,16'h0000,1'b1,1'b0}, // R5: A->box0 flags B
    {1'b1,1'b0,1'b1,6'd4, 2'b11,16'h0000,16'h1234,1'b1,1'b1}, // R4 R7: B reads, clears
    {1'b0,1'b1,1'b0,6'd1, 2'b01,16'hABCD,16'h0000,1'b1,1'b0}, // R3 low lane
    {1'b0,1'b1,1'b0,6'd1, 2'b10,16'h5678,16'h0000,1'b1,1'b0}, // R3 high lane
    {1'b0,1'b0,1'b1,6'd1, 2'b11,16'h0000,16'h56CD,1'b1,1'b0}, // R4 own box, R7 no clear
    {1'b1,1'b0,1'b1,6'd5, 2'b01,16'h0000,16'h00CD,1'b1,1'b1}, // R4 lane mask, R7
    {1'b1,1'b1,1'b0,6'd3, 2'b11,16'hBEEF,16'h0000,1'b0,1'b1}, // R5 B->A
    {1'b0,1'b1,1'b0,6'd8, 2'b01,16'h0007,16'h0000,1'b1,1'b1}, // R9 mask hides flag3
    {1'b0,1'b0,1'b1,6'd8, 2'b11,16'h0000,16'h0007,1'b1,1'b1}, // R4 mask readback
    {1'b0,1'b1,1'b0,6'd8, 2'b01,16'h000F,16'h0000,1'b0,1'b1}, // R9 R6 unmask
    {1'b0,1'b0,1'b1,6'd7, 2'b11,16'h0000,16'hBEEF,1'b1,1'b1}, // R4 R7
    {1'b0,1'b0,1'b1,6'd9, 2'b11,16'h0000,16'h0000,1'b1,1'b1}, // R4 unmapped
    {1'b0,1'b1,1'b0,6'd12,2'b11,16'hFFFF,16'h0000,1'b1,1'b1}, // R4 unmapped write
    {1'b1,1'b0,1'b1,6'd3, 2'b11,16'h0000,16'hBEEF,1'b1,1'b1}, // R4 own box
    {1'b0,1'b1,1'b0,6'd2, 2'b00,16'h1111,16'h0000,1'b1,1'b1}, // R2 no lanes
    {1'b1,1'b0,1'b1,6'd6, 2'b11,16'h0000,16'h0000,1'b1,1'b1}  // R2 box2 still 0
  };

  task automatic idle();
    {a_box_sel_n, a_cs, a_wr, a_rd, a_lane, a_addr, a_wdata} = {1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 6'd0, 16'h0};
    {b_box_sel_n, b_cs, b_wr, b_rd, b_lane, b_addr, b_wdata} = {1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 6'd0, 16'h0};
  endtask

  task automatic drive(input bit p, input bit sn, input bit c, input bit w, input bit r,
                       input logic [1:0] ln, input logic [5:0] ad, input logic [15:0] d);
    if (!p) {a_box_sel_n, a_cs, a_wr, a_rd, a_lane, a_addr, a_wdata} = {sn, c, w, r, ln, ad, d};
    else    {b_box_sel_n, b_cs, b_wr, b_rd, b_lane, b_addr, b_wdata} = {sn, c, w, r, ln, ad, d};
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1: values straight out of reset
    chk("R1 a_rdata", a_rdata, 16'h0);
    chk("R1 b_rdata", b_rdata, 16'h0);
    chk("R1 a_irq_n", {15'h0, a_irq_n}, 16'h1);
    chk("R1 b_irq_n", {15'h0, b_irq_n}, 16'h1);
    rst_n = 1'b1;
    step();
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 6'd8, 16'h0);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 6'd8, 16'h0);
    step();
    chk("R1 a mask", a_rdata, 16'h000F);
    chk("R1 b mask", b_rdata, 16'h000F);
    idle();

    for (int v = 0; v < NV; v++) begin
      logic [44:0] e;
      e = VEC[v];
      drive(e[44], 1'b0, 1'b1, e[43], e[42], e[35:34], e[41:36], e[33:18]);
      step();
      if (e[42]) chk($sformatf("R4 vec%0d rdata", v), e[44] ? b_rdata : a_rdata, e[17:2]);
      chk($sformatf("R6 vec%0d a_irq_n", v), {15'h0, a_irq_n}, {15'h0, e[1]});
      chk($sformatf("R6 vec%0d b_irq_n", v), {15'h0, b_irq_n}, {15'h0, e[0]});
      idle();
    end

    // R2: select high, then chip deselected: no write lands
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 6'd0, 16'h9999);
    step();
    chk("R2 sel high irq", {15'h0, b_irq_n}, 16'h1);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b11, 6'd0, 16'h9999);
    step();
    chk("R2 cs low irq", {15'h0, b_irq_n}, 16'h1);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 6'd4, 16'h0);
    step();
    chk("R2 box0 unchanged", b_rdata, 16'h1234);
    idle();
    step();
    chk("R4 hold idle", b_rdata, 16'h1234);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 6'd5, 16'h0);
    step();
    chk("R2 read sel high hold", b_rdata, 16'h1234);

    // R8: write and clearing read on one edge
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 6'd0, 16'h4321);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 6'd4, 16'h0);
    step();
    chk("R8 old word read", b_rdata, 16'h1234);
    chk("R8 set wins irq", {15'h0, b_irq_n}, 16'h0);
    idle();
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 6'd4, 16'h0);
    step();
    chk("R8 new word", b_rdata, 16'h4321);
    chk("R7 cleared", {15'h0, b_irq_n}, 16'h1);
    idle();

    // R10: write and read strobes together act as a write
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 6'd1, 16'h0F0F);
    step();
    chk("R10 a_rdata hold", a_rdata, 16'h0000);
    chk("R10 flag set", {15'h0, b_irq_n}, 16'h0);
    idle();
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 6'd5, 16'h0);
    step();
    chk("R10 written word", b_rdata, 16'h0F00);
    chk("R7 cleared box1", {15'h0, b_irq_n}, 16'h1);
    idle();

    // R9: masked flag persists, high-lane-only mask write ignored
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 6'd8, 16'h0000);
    step();
    idle();
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 6'd2, 16'h7777);
    step();
    chk("R9 masked irq", {15'h0, b_irq_n}, 16'h1);
    idle();
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 6'd8, 16'h0004);
    step();
    chk("R9 unmask shows kept flag", {15'h0, b_irq_n}, 16'h0);
    idle();
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 6'd8, 16'h000F);
    step();
    idle();
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 6'd8, 16'h0);
    step();
    chk("R9 high-lane mask write ignored", b_rdata, 16'h0004);
    chk("R9 irq still low", {15'h0, b_irq_n}, 16'h0);
    idle();
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 6'd6, 16'h0);
    step();
    chk("R4 box2 word", b_rdata, 16'h7777);
    chk("R7 box2 cleared", {15'h0, b_irq_n}, 16'h1);
    idle();
    step();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule